// File: doc/BRIEF.md
# Serial Receiver Status and Overrun Control

This block sits behind the receive shift register of an asynchronous serial port. When the shift register announces a finished byte with a one-cycle strobe, the block moves that byte into a data register the processor can read. It raises a "data register full" flag when it does so. If another byte arrives before the processor has collected the previous one, the block raises an "overrun" flag, keeps the old byte intact and throws the new one away.

The block also watches the line for an idle condition. On every bit tick it counts consecutive 1 bits, and it raises an "idle" flag once the run reaches the minimum for the frame format in use. A receiver-wakeup control input suppresses idle reporting. Once the idle flag has been cleared, detection stays disarmed until a fresh byte has been loaded.

All three flags are cleared by the same two-step access. A read of the status register records which flags were set at that moment. A later read of the data register then clears exactly those flags. Reads go through a simple read port, and the read data shows the selected register combinationally.

Top module: `serial_rx_status`

## Requirements
- R1: After synchronous reset the status register reads 0x00, the data register reads 0x00 and idle detection is armed.
- R2: A byte strobe that arrives while the full flag and the overrun flag are both clear loads the byte into the data register, and the full flag reads 1 from the next cycle.
- R3: rd_addr 0 selects the status register and rd_addr 1 selects the data register. The status layout is bit 0 full, bit 1 idle and bit 2 overrun, with the upper bits zero. rd_data shows the selected register whether or not rd_en is high.
- R4: A status read (rd_en with rd_addr 0) records the flags that are set in that cycle. The next data read (rd_en with rd_addr 1) clears exactly the recorded flags. A data read with nothing recorded clears nothing, and a flag that sets after the status read survives the data read.
- R5: A byte strobe that arrives while the full flag is set raises the overrun flag from the next cycle, and the data register keeps its earlier byte.
- R6: While the full flag or the overrun flag is set, every arriving byte is discarded and the data register does not change. After both flags are cleared, the next byte loads normally.
- R7: On each bit tick, a 1 on the line extends the run of consecutive ones and a 0 resets it. The idle flag sets on the tick that brings the run to 10 when long_frame is 0, or to 11 when long_frame is 1.
- R8: The idle flag does not set on a threshold tick while wake_hold is 1. Further ones on the same run do not set it later.
- R9: After the idle flag has been cleared by the clear sequence, no run of ones sets it again until a byte has been loaded into the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | One-cycle strobe: a received byte is ready |
| byte_in | input | 8 | Received byte from the shift register |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| line_bit | input | 1 | Line level sampled for this bit tick |
| long_frame | input | 1 | 1 selects the 11-bit idle run, 0 the 10-bit run |
| wake_hold | input | 1 | Receiver-wakeup control; blocks idle reporting |
| rd_en | input | 1 | Register read access strobe |
| rd_addr | input | 1 | 0 selects status, 1 selects data |
| rd_data | output | 8 | Contents of the selected register |

## Verification
A flag register stuck in a wrong state shows up in the status byte on the cycle right after the event that should have changed it, because every flag update is a single register stage. A wrong clear record or a lost idle arming state stays invisible until the next data read or the next long run of ones. The bench therefore drives sequences that end exactly on those events: a data read with no status read before it, a clear followed by a long run of ones, and a threshold tick under wake_hold. A corrupted data register under overrun shows on the first data-register peek after the discarded byte.

// File: rtl/srs_pkg.sv
package srs_pkg;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_DATA   = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic ovr;
        logic idle;
        logic full;
    } rx_flags_t;

    localparam int FLAG_W = $bits(rx_flags_t);

    function automatic int unsigned idle_limit(logic long_sel, int unsigned short_n,
                                               int unsigned long_n);
        return long_sel ? long_n : short_n;
    endfunction

endpackage

// File: rtl/rxs_data_hold.sv
module rxs_data_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          byte_valid,
    input  logic [DW-1:0] byte_in,
    input  logic          clr_full,
    input  logic          clr_ovr,
    output logic          full_q,
    output logic          ovr_q,
    output logic [DW-1:0] data_q,
    output logic          load_o
);
    logic ovr_set;

    assign load_o  = byte_valid && !full_q && !ovr_q;
    assign ovr_set = byte_valid && full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
            data_q <= '0;
        end else begin
            if (load_o) begin
                data_q <= byte_in;
                full_q <= 1'b1;
            end else if (clr_full) begin
                full_q <= 1'b0;
            end
            if (ovr_set) begin
                ovr_q <= 1'b1;
            end else if (clr_ovr) begin
                ovr_q <= 1'b0;
            end
        end
    end

    // R6: held byte frozen while full or overrun
    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (full_q || ovr_q) |=> $stable(data_q));

    // R2: full only rises from a byte strobe
    assert_full_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(full_q) |-> $past(byte_valid));

    // R5: overrun only rises from a byte arriving while full
    assert_ovr_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_q) |-> $past(byte_valid && full_q));

    // R4: full only falls through the clear sequence
    assert_full_fall_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(full_q) |-> $past(clr_full));

endmodule

// File: rtl/rxs_idle_det.sv
module rxs_idle_det
    import srs_pkg::*;
#(
    parameter int IDLE_SHORT = 10,
    parameter int IDLE_LONG  = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_tick,
    input  logic line_bit,
    input  logic long_frame,
    input  logic wake_hold,
    input  logic rearm,
    input  logic clr_idle,
    output logic idle_q
);
    localparam int CW = $clog2(IDLE_LONG + 1);

    logic [CW-1:0] run_q;
    logic [CW-1:0] thr;
    logic [CW:0]   run_inc;
    logic          armed_q;
    logic          hit;

    assign thr     = CW'(idle_limit(long_frame, IDLE_SHORT, IDLE_LONG));
    assign run_inc = {1'b0, run_q} + (CW + 1)'(1);
    assign hit     = bit_tick && line_bit && (run_inc == {1'b0, thr})
                     && armed_q && !wake_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (bit_tick) begin
            if (!line_bit) begin
                run_q <= '0;
            end else if (run_q != CW'(IDLE_LONG)) begin
                run_q <= run_inc[CW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b1;
            idle_q  <= 1'b0;
        end else begin
            if (rearm) begin
                armed_q <= 1'b1;
            end else if (clr_idle) begin
                armed_q <= 1'b0;
            end
            if (hit) begin
                idle_q <= 1'b1;
            end else if (clr_idle) begin
                idle_q <= 1'b0;
            end
        end
    end

    // R8: wakeup control blocks idle reporting
    assert_no_idle_wake_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(idle_q) |-> !$past(wake_hold));

    // R9: idle only sets while detection is armed
    assert_idle_armed_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(idle_q) |-> $past(armed_q));

    // R7: idle only sets on a tick with a 1 on the line
    assert_idle_tick_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(idle_q) |-> $past(bit_tick && line_bit));

endmodule

// File: rtl/rxs_clear_seq.sv
module rxs_clear_seq
    import srs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      stat_rd,
    input  logic      data_rd,
    input  rx_flags_t flags,
    output rx_flags_t clr
);
    rx_flags_t seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
        end else if (stat_rd) begin
            seen_q <= flags;
        end else if (data_rd) begin
            seen_q <= '0;
        end
    end

    assign clr = data_rd ? seen_q : '0;

    // R4: a recorded flag was set at the status read that recorded it
    assert_seen_valid_R4: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !flags.full) |=> !seen_q.full);

endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
    import srs_pkg::*;
#(
    parameter int DW         = 8,
    parameter int IDLE_SHORT = 10,
    parameter int IDLE_LONG  = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          byte_valid,
    input  logic [DW-1:0] byte_in,
    input  logic          bit_tick,
    input  logic          line_bit,
    input  logic          long_frame,
    input  logic          wake_hold,
    input  logic          rd_en,
    input  logic          rd_addr,
    output logic [DW-1:0] rd_data
);
    reg_sel_e      sel;
    logic          stat_rd;
    logic          data_rd;
    rx_flags_t     flags;
    rx_flags_t     clr;
    logic          full_q;
    logic          ovr_q;
    logic          idle_q;
    logic          load;
    logic [DW-1:0] data_q;

    assign sel     = reg_sel_e'(rd_addr);
    assign stat_rd = rd_en && (sel == SEL_STATUS);
    assign data_rd = rd_en && (sel == SEL_DATA);

    always_comb begin
        flags      = '0;
        flags.full = full_q;
        flags.idle = idle_q;
        flags.ovr  = ovr_q;
    end

    rxs_clear_seq u_clear (
        .clk     (clk),
        .rst     (rst),
        .stat_rd (stat_rd),
        .data_rd (data_rd),
        .flags   (flags),
        .clr     (clr)
    );

    rxs_data_hold #(.DW(DW)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .clr_full   (clr.full),
        .clr_ovr    (clr.ovr),
        .full_q     (full_q),
        .ovr_q      (ovr_q),
        .data_q     (data_q),
        .load_o     (load)
    );

    rxs_idle_det #(.IDLE_SHORT(IDLE_SHORT), .IDLE_LONG(IDLE_LONG)) u_idle (
        .clk        (clk),
        .rst        (rst),
        .bit_tick   (bit_tick),
        .line_bit   (line_bit),
        .long_frame (long_frame),
        .wake_hold  (wake_hold),
        .rearm      (load),
        .clr_idle   (clr.idle),
        .idle_q     (idle_q)
    );

    always_comb begin
        if (sel == SEL_DATA) begin
            rd_data = data_q;
        end else begin
            rd_data = {{(DW - FLAG_W){1'b0}}, flags};
        end
    end

    // R1: flags clear right after reset
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (flags == '0));

endmodule

// File: tb/serial_rx_status_tb_top.sv
`timescale 1ns/1ps
module serial_rx_status_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       bit_tick = 1'b0;
    logic       line_bit = 1'b1;
    logic       long_frame = 1'b0;
    logic       wake_hold = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural reference state
    bit m_full, m_idle, m_ovr, m_armed;
    bit [2:0] m_seen;
    bit [7:0] m_data;
    int m_run;

    always #2.5 clk = ~clk;

    serial_rx_status dut_i (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_in(byte_in),
        .bit_tick(bit_tick), .line_bit(line_bit), .long_frame(long_frame),
        .wake_hold(wake_hold), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    // reference model, updated on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_full = 0; m_idle = 0; m_ovr = 0; m_armed = 1;
            m_seen = 0; m_data = 0; m_run = 0;
        end else begin
            bit load, oset, hit;
            bit [2:0] clrv;
            int thr;
            thr  = long_frame ? 11 : 10;
            load = byte_valid && !m_full && !m_ovr;
            oset = byte_valid && m_full;
            clrv = (rd_en && rd_addr) ? m_seen : 3'b000;
            hit  = bit_tick && line_bit && (m_run + 1 == thr) && m_armed && !wake_hold;
            if (rd_en && !rd_addr) m_seen = {m_ovr, m_idle, m_full};
            else if (rd_en && rd_addr) m_seen = 3'b000;
            if (load) begin m_full = 1; m_data = byte_in; end
            else if (clrv[0]) m_full = 0;
            if (oset) m_ovr = 1; else if (clrv[2]) m_ovr = 0;
            if (hit) m_idle = 1; else if (clrv[1]) m_idle = 0;
            if (load) m_armed = 1; else if (clrv[1]) m_armed = 0;
            if (bit_tick) begin
                if (!line_bit) m_run = 0;
                else if (m_run < 11) m_run = m_run + 1;
            end
        end
        #1;
        if (!rst && !done) begin
            if (rd_addr) chk("R2 model data", rd_data, m_data);
            else chk("R3 model status", rd_data, {5'b0, m_ovr, m_idle, m_full});
        end
    end

    task automatic quiet();
        byte_valid = 0; bit_tick = 0; rd_en = 0;
    endtask

    task automatic send_byte(logic [7:0] b);
        @(negedge clk); quiet(); byte_valid = 1; byte_in = b;
    endtask

    task automatic stat_rd();
        @(negedge clk); quiet(); rd_en = 1; rd_addr = 0;
    endtask

    task automatic data_rd();
        @(negedge clk); quiet(); rd_en = 1; rd_addr = 1;
    endtask

    task automatic bits(int n, logic v);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); quiet(); bit_tick = 1; line_bit = v;
        end
    endtask

    task automatic peek(logic a, output logic [7:0] v);
        @(negedge clk); quiet(); rd_addr = a; #1; v = rd_data;
    endtask

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 0;
        peek(0, v); chk("R1 status after reset", v, 8'h00);
        peek(1, v); chk("R1 data after reset", v, 8'h00);

        send_byte(8'hA5);
        peek(0, v); chk("R2 full set on load", v, 8'h01);
        peek(1, v); chk("R2 data loaded", v, 8'hA5);
        rd_en = 0;
        @(negedge clk); quiet(); rd_en = 0; rd_addr = 0; #1;
        chk("R3 rd_data without rd_en", rd_data, 8'h01);

        data_rd();
        peek(0, v); chk("R4 data read alone clears nothing", v, 8'h01);
        stat_rd(); data_rd();
        peek(0, v); chk("R4 sequence clears full", v, 8'h00);

        send_byte(8'h3C); send_byte(8'hC3);
        peek(0, v); chk("R5 overrun flagged", v, 8'h05);
        peek(1, v); chk("R5 held byte kept", v, 8'h3C);
        send_byte(8'h77);
        peek(1, v); chk("R6 byte discarded in overrun", v, 8'h3C);
        stat_rd(); data_rd();
        peek(0, v); chk("R4 sequence clears full and overrun", v, 8'h00);
        send_byte(8'h11);
        peek(1, v); chk("R6 load resumes", v, 8'h11);
        stat_rd(); data_rd();

        stat_rd(); send_byte(8'h22); data_rd();
        peek(0, v); chk("R4 late flag survives", v, 8'h01);
        stat_rd(); data_rd();

        bits(1, 0); bits(9, 1);
        peek(0, v); chk("R7 no idle at 9 ones", v, 8'h00);
        bits(1, 1);
        peek(0, v); chk("R7 idle at 10 ones", v, 8'h02);
        stat_rd(); data_rd();
        peek(0, v); chk("R4 idle cleared", v, 8'h00);
        bits(1, 0); bits(12, 1);
        peek(0, v); chk("R9 idle disarmed after clear", v, 8'h00);

        send_byte(8'h33); stat_rd(); data_rd();
        long_frame = 1;
        bits(1, 0); bits(10, 1);
        peek(0, v); chk("R7 long frame no idle at 10", v, 8'h00);
        bits(1, 1);
        peek(0, v); chk("R7 long frame idle at 11", v, 8'h02);
        stat_rd(); data_rd();

        send_byte(8'h44); stat_rd(); data_rd();
        wake_hold = 1;
        bits(1, 0); bits(11, 1);
        peek(0, v); chk("R8 wake blocks idle", v, 8'h00);
        wake_hold = 0;
        bits(3, 1);
        peek(0, v); chk("R8 no late idle on same run", v, 8'h00);
        peek(1, v); chk("R2 data after wake phase", v, 8'h44);

        long_frame = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            byte_valid = ($urandom % 6) == 0;
            byte_in    = 8'($urandom);
            bit_tick   = ($urandom % 2) == 0;
            line_bit   = ($urandom % 12) != 0;
            rd_en      = ($urandom % 4) == 0;
            rd_addr    = 1'($urandom);
            wake_hold  = ($urandom % 10) == 0;
        end
        @(negedge clk); quiet();
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule